// File: doc/BRIEF.md
# Modem Status Change Register

This block keeps one serial channel's view of its modem-control inputs and its pending events in a single 32-bit status word. Four already-synchronised modem inputs (carrier detect, data set ready, clear to send, ring indicator) are sampled every clock. Their current levels are shown in the word. A transition in either direction on any of them sets a sticky change flag. Three event pulses from the data path are also latched as sticky flags: receive data available, receive overrun and transmitter empty.

Software reads the word and then writes it back. A written one clears the matching event flag. Level bits and unused bits ignore writes, so writing back the word just read clears exactly the events that were seen. If an event arrives in the same cycle as its clear, the event wins and no edge is lost. Three enable inputs gate the latched events onto a single interrupt request: one for the modem change flags as a group, one for receive data and one for transmitter empty.

Top module: `mstat_reg`

## Requirements
- R1: While reset is asserted, the status word reads zero and the interrupt request is low.
- R2: The level bits are carrier detect at bit 3, data set ready at bit 4, clear to send at bit 5 and ring indicator at bit 6. Each shows its input as sampled at the previous rising clock edge.
- R3: A rising or falling transition of a modem input sets its change flag at the edge where the level bit updates. The flags are data set ready at bit 16, clear to send at bit 17, carrier detect at bit 18 and ring indicator at bit 22. The first edge after reset release only loads the levels and sets no flag.
- R4: Every event flag stays set until it is cleared by a write.
- R5: A write (write enable high) clears each event flag whose bit is one in the written data. Zero bits, level bits and unused bits have no effect. Writing back the value just read keeps all level bits. Unused bits always read zero.
- R6: When a flag's set condition and its clear happen in the same cycle, the flag ends up set.
- R7: A one-cycle pulse on the receive-available input sets bit 0. A pulse on the overrun input sets bit 13. A pulse on the transmitter-empty input sets bit 25.
- R8: The interrupt request is high exactly when at least one of these holds: the modem enable is high and any change flag is set; the receive enable is high and bit 0 is set; the transmit enable is high and bit 25 is set. The overrun flag never drives it.
- R9: Lowering an enable removes its events from the interrupt request without clearing any latched flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcd_i | input | 1 | Synchronised carrier detect level |
| dsr_i | input | 1 | Synchronised data set ready level |
| cts_i | input | 1 | Synchronised clear to send level |
| ri_i | input | 1 | Synchronised ring indicator level |
| rx_avail_i | input | 1 | Receive data available event pulse |
| rx_ovr_i | input | 1 | Receive overrun event pulse |
| tx_empty_i | input | 1 | Transmitter empty event pulse |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 32 | Write data; ones clear event flags |
| rd_data_o | output | 32 | Status word: levels and latched events |
| ms_ie_i | input | 1 | Modem change interrupt enable |
| rx_ie_i | input | 1 | Receive data interrupt enable |
| tx_ie_i | input | 1 | Transmitter empty interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four modem lines and a 32-bit word. These fix every bit position that software decodes, so each level, change and event bit can be checked at its stated place. Directed steps cover a line held high through reset release, transitions that coincide with their own clear, and a write with all ones. Random toggling, writes of random masks and read-then-write-back sequences then exercise coincident sets and clears on all seven flags with the enables in every combination.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int WORD_W  = 32;
  localparam int N_LINES = 4;            // order: carrier, dsr, cts, ring
  localparam int N_EVT   = N_LINES + 3;  // change flags, rx, overrun, tx
  localparam int EVT_RX  = N_LINES;
  localparam int EVT_OVR = N_LINES + 1;
  localparam int EVT_TX  = N_LINES + 2;

  // bit position of a line's level in the status word
  function automatic int lvl_pos(input int line);
    return 3 + line;
  endfunction

  // bit position of each sticky event flag in the status word
  function automatic int evt_pos(input int idx);
    case (idx)
      0:       return 18;
      1:       return 16;
      2:       return 17;
      3:       return 22;
      EVT_RX:  return 0;
      EVT_OVR: return 13;
      default: return 25;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] evt_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < N_EVT; k++) m[evt_pos(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] used_mask();
    logic [WORD_W-1:0] m;
    m = evt_mask();
    for (int i = 0; i < N_LINES; i++) m[lvl_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mstat_edge.sv
module mstat_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o
);
  logic         armed_q, armed_d;
  logic [N-1:0] lvl_q, lvl_d;

  always_comb begin
    armed_d = 1'b1;
    lvl_d   = lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    assign chg_o[g] = armed_q & (lvl_i[g] ^ lvl_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      lvl_q   <= '0;
    end else begin
      armed_q <= armed_d;
      lvl_q   <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  // R3: no change reported on the very first edge after reset release
  p_no_first_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (chg_o == '0));
endmodule

// File: rtl/mstat_sticky.sv
module mstat_sticky #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         upd;

  always_comb begin
    upd = (|set_i) | (|(clr_i & q_q));
    q_d = set_i | (q_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_q <= '0;
    else if (upd) q_q <= q_d;
  end

  assign q_o = q_q;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o != '0) |=> ((($past(q_o) & ~$past(clr_i)) & ~q_o) == '0));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/mstat_irq.sv
module mstat_irq #(
  parameter int N = 4
) (
  input  logic [N-1:0] chg_i,
  input  logic         rx_evt_i,
  input  logic         tx_evt_i,
  input  logic         ms_ie_i,
  input  logic         rx_ie_i,
  input  logic         tx_ie_i,
  output logic         irq_o
);
  always_comb begin
    irq_o = (ms_ie_i & (|chg_i)) | (rx_ie_i & rx_evt_i) | (tx_ie_i & tx_evt_i);
  end
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
  import mstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcd_i,
  input  logic              dsr_i,
  input  logic              cts_i,
  input  logic              ri_i,
  input  logic              rx_avail_i,
  input  logic              rx_ovr_i,
  input  logic              tx_empty_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              ms_ie_i,
  input  logic              rx_ie_i,
  input  logic              tx_ie_i,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] EVT_MASK  = evt_mask();
  localparam logic [WORD_W-1:0] USED_MASK = used_mask();

  logic [N_LINES-1:0] lvl_in, lvl, chg;
  logic [N_EVT-1:0]   evt_set, evt_clr, evt;
  logic               unused_wr_bits;

  assign lvl_in         = {ri_i, cts_i, dsr_i, dcd_i};
  assign unused_wr_bits = ^(wr_data_i & ~EVT_MASK);

  mstat_edge #(.N(N_LINES)) edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl_in),
    .lvl_o (lvl),
    .chg_o (chg)
  );

  assign evt_set = {tx_empty_i, rx_ovr_i, rx_avail_i, chg};

  for (genvar k = 0; k < N_EVT; k++) begin : g_clr
    assign evt_clr[k] = wr_en_i & wr_data_i[evt_pos(k)];
  end

  mstat_sticky #(.W(N_EVT)) sticky_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_set),
    .clr_i (evt_clr),
    .q_o   (evt)
  );

  mstat_irq #(.N(N_LINES)) irq_i (
    .chg_i    (evt[N_LINES-1:0]),
    .rx_evt_i (evt[EVT_RX]),
    .tx_evt_i (evt[EVT_TX]),
    .ms_ie_i  (ms_ie_i),
    .rx_ie_i  (rx_ie_i),
    .tx_ie_i  (tx_ie_i),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_LINES; i++) rd_data_o[lvl_pos(i)] = lvl[i];
    for (int k = 0; k < N_EVT; k++)   rd_data_o[evt_pos(k)] = evt[k];
  end

  p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_data_o[6:3] == $past(lvl_in)));
  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~USED_MASK) == '0);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_en_i) |=> (irq_o || !$stable({ms_ie_i, rx_ie_i, tx_ie_i})));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (rd_data_o == '0 && !irq_o));
endmodule

// File: tb/mstat_reg_tb.sv
`timescale 1ns/1ps
module mstat_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dcd, dsr, cts, ri, rxp, ovp, txp, we;
  logic [31:0] wd;
  logic        msie, rxie, txie;
  logic [31:0] rd;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the register state
  logic [3:0] m_lvl, m_chg;   // order: carrier, dsr, cts, ring
  logic       m_rx, m_ovr, m_tx, m_armed;

  always #2 clk = ~clk;

  mstat_reg dut_i (
    .clk(clk), .rst_n(rst_n), .dcd_i(dcd), .dsr_i(dsr), .cts_i(cts), .ri_i(ri),
    .rx_avail_i(rxp), .rx_ovr_i(ovp), .tx_empty_i(txp),
    .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd),
    .ms_ie_i(msie), .rx_ie_i(rxie), .tx_ie_i(txie), .irq_o(irq)
  );

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = '0;
    w[3] = m_lvl[0]; w[4] = m_lvl[1]; w[5] = m_lvl[2]; w[6] = m_lvl[3];
    w[18] = m_chg[0]; w[16] = m_chg[1]; w[17] = m_chg[2]; w[22] = m_chg[3];
    w[0] = m_rx; w[13] = m_ovr; w[25] = m_tx;
    return w;
  endfunction

  function automatic logic exp_irq();
    return (msie & (|m_chg)) | (rxie & m_rx) | (txie & m_tx);
  endfunction

  task automatic model_step();
    logic [31:0] c;
    logic [3:0]  in;
    int          cp [4];
    c  = we ? wd : 32'h0;
    in = {ri, cts, dsr, dcd};
    cp[0] = 18; cp[1] = 16; cp[2] = 17; cp[3] = 22;
    for (int i = 0; i < 4; i++)
      m_chg[i] = (m_armed && (in[i] != m_lvl[i])) | (m_chg[i] & ~c[cp[i]]);
    m_rx    = rxp | (m_rx  & ~c[0]);
    m_ovr   = ovp | (m_ovr & ~c[13]);
    m_tx    = txp | (m_tx  & ~c[25]);
    m_lvl   = in;
    m_armed = 1'b1;
  endtask

  task automatic compare(input string tag);
    total++;
    if (rd !== exp_word()) begin
      bad++;
      $display("FAIL %s word actual=%h expected=%h", tag, rd, exp_word());
    end
    total++;
    if (irq !== exp_irq()) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq());
    end
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    rxp = 0; ovp = 0; txp = 0; we = 0; wd = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    rst_n = 0; dcd = 1; dsr = 0; cts = 0; ri = 0;
    rxp = 0; ovp = 0; txp = 0; we = 0; wd = '0;
    msie = 1; rxie = 1; txie = 1;
    m_lvl = '0; m_chg = '0; m_rx = 0; m_ovr = 0; m_tx = 0; m_armed = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    step("R3 first edge loads level only");
    step("R2 level held");
    cts = 1; step("R3 rising cts");
    cts = 0; step("R3 falling cts");
    repeat (3) step("R4 flag holds");
    we = 1; wd = 32'h0; step("R5 zero write no effect");
    we = 1; wd = 32'hffff_ffff; step("R5 all-ones write keeps levels");
    ri = 1; we = 1; wd = 32'h0040_0000; step("R6 ring change beats clear");
    dsr = 1; step("R2 dsr level");
    rxp = 1; step("R7 rx pulse");
    ovp = 1; step("R7 overrun pulse");
    txp = 1; step("R7 tx pulse");
    we = 1; wd = 32'h0000_2000; step("R5 clear overrun only");
    msie = 0; rxie = 0; txie = 0; step("R9 enables off keep flags");
    txie = 1; step("R8 tx enable alone");
    we = 1; wd = rd; step("R5 write back read value");
    ovp = 1; msie = 1; rxie = 1; step("R8 overrun alone no irq");
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0) dcd = ~dcd;
      if ($urandom_range(0, 7) == 0) dsr = ~dsr;
      if ($urandom_range(0, 7) == 0) cts = ~cts;
      if ($urandom_range(0, 7) == 0) ri  = ~ri;
      rxp = ($urandom_range(0, 5) == 0);
      ovp = ($urandom_range(0, 9) == 0);
      txp = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 7) == 0) begin
        msie = $urandom_range(0, 1); rxie = $urandom_range(0, 1); txie = $urandom_range(0, 1);
      end
      case ($urandom_range(0, 3))
        0: begin we = 1; wd = $urandom(); end
        1: begin we = 1; wd = rd; end
        default: begin we = 0; wd = $urandom(); end
      endcase
      step("R5 random mix");
    end
    finish_run();
  end
endmodule